// File: doc/BRIEF.md
# Eight-to-four largest-key selector

This block takes eight keys on one wide bus, marked by a valid strobe, and returns the four largest of them on four result ports with their own valid strobe. It serves as a pre-filter wherever only the top few candidates of a batch are needed, such as picking the strongest channels or the best-scoring entries. Nothing downstream may assume the four results come out in any particular order.

Inside, two four-key bitonic sorters run side by side. One sorts keys 0..3 into ascending order and the other sorts keys 4..7 into descending order. Each takes three compare-and-exchange levels. A fourth level of plain max cells then pairs position i of each half, keeps the larger key and throws the smaller away. The result is the upper half of the combined set after four levels, where a full eight-key sort would take six. A register may follow each of the four levels. A mask parameter picks which levels get one, and that mask sets the latency. The key width and the signedness of the comparison are also parameters.

Top module: `maxset8to4`

## Requirements
- R1: Key k sits in bits [k*KEY_W +: KEY_W] of keys_i. For every accepted vector, {h0_o,h1_o,h2_o,h3_o} is exactly the multiset of the four largest input keys, with duplicates counted.
- R2: The largest input key always appears on at least one result port.
- R3: Every result equals one of the eight input keys, and no key value appears among the results more often than it appears among the inputs.
- R4: With SIGNED_KEYS=0 keys compare as unsigned numbers. With SIGNED_KEYS=1 they compare as two's-complement numbers, so a key with its top bit set ranks below every key with its top bit clear.
- R5: Bit s of STAGE_REGS (s=0..3) places a register after network level s+1. valid_o goes high exactly N cycles after the matching valid_i, where N is the number of set bits in STAGE_REGS. valid_o never goes high without a matching accepted input.
- R6: While rst_ni is low, valid_o is low, whatever is driven on valid_i.
- R7: Repeated keys need no special handling: when all eight inputs are equal, all four results carry that value.
- R8: A new vector may be accepted every cycle. Each accepted vector yields exactly one valid result, and results come out in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | keys_i holds a vector to process |
| keys_i | input | 8*KEY_W | Eight input keys, key k in bits [k*KEY_W +: KEY_W] |
| valid_o | output | 1 | Result ports hold a selected set |
| h0_o | output | KEY_W | Selected key, lane 0 |
| h1_o | output | KEY_W | Selected key, lane 1 |
| h2_o | output | KEY_W | Selected key, lane 2 |
| h3_o | output | KEY_W | Selected key, lane 3 |

## Verification
The bench builds two instances with 3-bit keys:
- **Unsigned instance.** Registers after all four levels.
- **Signed instance.** Registers after levels 1 and 3 only, which gives a latency of two and leaves a combinational final max level.

With three-bit keys, every one of the 256 two-valued input patterns can be applied. By the zero-one principle for comparator networks, that proves the selection wiring. The small alphabet also makes repeated keys and sign-boundary comparisons frequent during the long random stream that follows, which has idle gaps. Both instances receive the same vectors back to back, so throughput, ordering and the latency for the chosen mask are checked on every result.

// File: rtl/maxset_pkg.sv
package maxset_pkg;
  localparam int N_KEYS     = 8;
  localparam int N_SEL      = 4;
  localparam int HALF       = 4;
  localparam int SORT_LVLS  = 3;
  localparam int NET_LVLS   = 4;

  // first member of pair p at sort level lvl (index within a half)
  function automatic int pair_a(input int lvl, input int p);
    return (lvl == 1) ? p : 2 * p;
  endfunction

  function automatic int pair_b(input int lvl, input int p);
    return (lvl == 1) ? p + 2 : 2 * p + 1;
  endfunction

  // 1: lower index receives the smaller key
  function automatic bit pair_up(input int lvl, input int p, input int half);
    bit up;
    up = (lvl == 0) ? (p == 0) : 1'b1;
    return (half == 0) ? up : !up;
  endfunction

  function automatic int reg_count(input logic [NET_LVLS-1:0] mask);
    int n;
    n = 0;
    for (int i = 0; i < NET_LVLS; i++) n += int'(mask[i]);
    return n;
  endfunction
endpackage

// File: rtl/cae_cell.sv
module cae_cell #(
  parameter int KEY_W       = 10,
  parameter bit SIGNED_KEYS = 1'b0,
  parameter bit ASCEND      = 1'b1
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  output logic [KEY_W-1:0] x_o,
  output logic [KEY_W-1:0] y_o
);
  localparam logic [KEY_W-1:0] FLIP = {SIGNED_KEYS, {(KEY_W-1){1'b0}}};

  logic a_gt_b;
  assign a_gt_b = (a_i ^ FLIP) > (b_i ^ FLIP);

  always_comb begin
    if (a_gt_b == ASCEND) begin
      x_o = b_i;
      y_o = a_i;
    end else begin
      x_o = a_i;
      y_o = b_i;
    end
  end
endmodule

// File: rtl/max_cell.sv
module max_cell #(
  parameter int KEY_W       = 10,
  parameter bit SIGNED_KEYS = 1'b0
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  output logic [KEY_W-1:0] m_o
);
  localparam logic [KEY_W-1:0] FLIP = {SIGNED_KEYS, {(KEY_W-1){1'b0}}};

  assign m_o = ((a_i ^ FLIP) >= (b_i ^ FLIP)) ? a_i : b_i;
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/maxset8to4.sv
module maxset8to4 #(
  parameter int          KEY_W       = 10,
  parameter bit          SIGNED_KEYS = 1'b0,
  parameter logic [3:0]  STAGE_REGS  = 4'b1111
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [8*KEY_W-1:0]   keys_i,
  output logic                 valid_o,
  output logic [KEY_W-1:0]     h0_o,
  output logic [KEY_W-1:0]     h1_o,
  output logic [KEY_W-1:0]     h2_o,
  output logic [KEY_W-1:0]     h3_o
);
  import maxset_pkg::*;

  localparam int BUS_W = N_KEYS * KEY_W;
  localparam int SEL_W = N_SEL * KEY_W;

  logic [BUS_W-1:0] lvl_d [SORT_LVLS+1];
  logic             lvl_v [SORT_LVLS+1];
  logic [BUS_W-1:0] cae_q [SORT_LVLS];
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_r;

  assign lvl_d[0] = keys_i;
  assign lvl_v[0] = valid_i;

  // levels 1..3: two 4-key bitonic sorters, lower half ascending, upper descending
  for (genvar lv = 0; lv < SORT_LVLS; lv++) begin : g_lvl
    for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar p = 0; p < 2; p++) begin : g_pair
        localparam int IA = h * HALF + pair_a(lv, p);
        localparam int IB = h * HALF + pair_b(lv, p);
        localparam bit UP = pair_up(lv, p, h);
        cae_cell #(.KEY_W(KEY_W), .SIGNED_KEYS(SIGNED_KEYS), .ASCEND(UP)) u_cae (
          .a_i(lvl_d[lv][IA*KEY_W +: KEY_W]),
          .b_i(lvl_d[lv][IB*KEY_W +: KEY_W]),
          .x_o(cae_q[lv][IA*KEY_W +: KEY_W]),
          .y_o(cae_q[lv][IB*KEY_W +: KEY_W])
        );
      end
    end

    if (STAGE_REGS[lv]) begin : g_reg
      stage_reg #(.W(BUS_W)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(lvl_v[lv]),
        .d_i    (cae_q[lv]),
        .valid_o(lvl_v[lv+1]),
        .q_o    (lvl_d[lv+1])
      );
    end else begin : g_wire
      assign lvl_d[lv+1] = cae_q[lv];
      assign lvl_v[lv+1] = lvl_v[lv];
    end
  end

  // level 4: keep the larger of each cross pair
  for (genvar i = 0; i < N_SEL; i++) begin : g_max
    max_cell #(.KEY_W(KEY_W), .SIGNED_KEYS(SIGNED_KEYS)) u_max (
      .a_i(lvl_d[SORT_LVLS][i*KEY_W +: KEY_W]),
      .b_i(lvl_d[SORT_LVLS][(HALF+i)*KEY_W +: KEY_W]),
      .m_o(sel_q[i*KEY_W +: KEY_W])
    );
  end

  if (STAGE_REGS[NET_LVLS-1]) begin : g_out_reg
    stage_reg #(.W(SEL_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(lvl_v[SORT_LVLS]),
      .d_i    (sel_q),
      .valid_o(valid_o),
      .q_o    (sel_r)
    );
  end else begin : g_out_wire
    assign sel_r   = sel_q;
    assign valid_o = lvl_v[SORT_LVLS];
  end

  assign h0_o = sel_r[0*KEY_W +: KEY_W];
  assign h1_o = sel_r[1*KEY_W +: KEY_W];
  assign h2_o = sel_r[2*KEY_W +: KEY_W];
  assign h3_o = sel_r[3*KEY_W +: KEY_W];
endmodule

// File: rtl/maxset8to4_chk.sv
module maxset8to4_chk #(
  parameter int          KEY_W       = 10,
  parameter bit          SIGNED_KEYS = 1'b0,
  parameter logic [3:0]  STAGE_REGS  = 4'b1111
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [8*KEY_W-1:0] keys_i,
  input logic               valid_o,
  input logic [KEY_W-1:0]   h0_o,
  input logic [KEY_W-1:0]   h1_o,
  input logic [KEY_W-1:0]   h2_o,
  input logic [KEY_W-1:0]   h3_o
);
  localparam int LAT = maxset_pkg::reg_count(STAGE_REGS);
  localparam logic [KEY_W-1:0] FLIP = {SIGNED_KEYS, {(KEY_W-1){1'b0}}};

  logic               dv [LAT+1];
  logic [8*KEY_W-1:0] dk [LAT+1];

  assign dv[0] = valid_i;
  assign dk[0] = keys_i;

  for (genvar i = 1; i <= LAT; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dv[i] <= 1'b0;
      else         dv[i] <= dv[i-1];
    end
    always_ff @(posedge clk_i) dk[i] <= dk[i-1];
  end

  logic [KEY_W-1:0] outs [4];
  assign outs[0] = h0_o;
  assign outs[1] = h1_o;
  assign outs[2] = h2_o;
  assign outs[3] = h3_o;

  logic top_ok, member_ok, max_ok;

  always_comb begin
    logic [KEY_W-1:0] t, big;
    int n_in, n_out, want;
    bit hit;
    top_ok    = 1'b1;
    member_ok = 1'b1;
    big       = dk[LAT][KEY_W-1:0];
    for (int j = 0; j < 8; j++) begin
      t = dk[LAT][j*KEY_W +: KEY_W];
      if ((t ^ FLIP) > (big ^ FLIP)) big = t;
      n_in  = 0;
      n_out = 0;
      for (int k = 0; k < 8; k++)
        if ((dk[LAT][k*KEY_W +: KEY_W] ^ FLIP) >= (t ^ FLIP)) n_in++;
      for (int k = 0; k < 4; k++)
        if ((outs[k] ^ FLIP) >= (t ^ FLIP)) n_out++;
      want = (n_in > 4) ? 4 : n_in;
      if (n_out != want) top_ok = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      hit = 1'b0;
      for (int j = 0; j < 8; j++)
        if (outs[k] == dk[LAT][j*KEY_W +: KEY_W]) hit = 1'b1;
      if (!hit) member_ok = 1'b0;
    end
    max_ok = (outs[0] == big) || (outs[1] == big) || (outs[2] == big) || (outs[3] == big);
  end

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == dv[LAT]);

  a_r1_top_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> top_ok);

  a_r3_member: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> member_ok);

  a_r2_max_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> max_ok);
endmodule

bind maxset8to4 maxset8to4_chk #(
  .KEY_W(KEY_W), .SIGNED_KEYS(SIGNED_KEYS), .STAGE_REGS(STAGE_REGS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .keys_i(keys_i),
  .valid_o(valid_o), .h0_o(h0_o), .h1_o(h1_o), .h2_o(h2_o), .h3_o(h3_o)
);

// File: tb/maxset8to4_test.sv
module maxset8to4_test;
  localparam int KW = 3;
  localparam int LAT0 = 4;
  localparam int LAT1 = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [8*KW-1:0] keys = '0;
  logic v0, v1;
  logic [KW-1:0] a0, a1, a2, a3, b0, b1, b2, b3;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8*KW-1:0] q0[$], q1[$];
  int t0[$], t1[$];
  string g0[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  maxset8to4 #(.KEY_W(KW), .SIGNED_KEYS(1'b0), .STAGE_REGS(4'b1111)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .keys_i(keys),
    .valid_o(v0), .h0_o(a0), .h1_o(a1), .h2_o(a2), .h3_o(a3));

  maxset8to4 #(.KEY_W(KW), .SIGNED_KEYS(1'b1), .STAGE_REGS(4'b0101)) uut_signed (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .keys_i(keys),
    .valid_o(v1), .h0_o(b0), .h1_o(b1), .h2_o(b2), .h3_o(b3));

  function automatic int kval(input logic [KW-1:0] k, input bit sgn);
    return sgn ? int'($signed(k)) : int'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic judge(input logic [8*KW-1:0] in, input int o[4], input bit sgn,
                       input int stamp, input int lat, input string tag);
    int iv[8];
    int os[4];
    int tmp;
    bit ok, hit;
    for (int i = 0; i < 8; i++) iv[i] = kval(in[i*KW +: KW], sgn);
    for (int i = 0; i < 4; i++) os[i] = o[i];
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (iv[j] < iv[j+1]) begin tmp = iv[j]; iv[j] = iv[j+1]; iv[j+1] = tmp; end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (os[j] < os[j+1]) begin tmp = os[j]; os[j] = os[j+1]; os[j+1] = tmp; end
    chk(cyc - stamp == lat, "R5", "latency", cyc - stamp, lat);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (os[i] != iv[i]) ok = 1'b0;
    for (int i = 0; i < 4; i++)
      if (os[i] != iv[i]) begin
        chk(1'b0, sgn ? "R4" : tag, "top-four rank", os[i], iv[i]);
        break;
      end
    if (ok) chk(1'b1, sgn ? "R4" : tag, "top-four", 0, 0);
    chk(os[0] == iv[0], "R2", "largest kept", os[0], iv[0]);
    for (int k = 0; k < 4; k++) begin
      hit = 1'b0;
      for (int j = 0; j < 8; j++) if (o[k] == kval(in[j*KW +: KW], sgn)) hit = 1'b1;
      chk(hit, "R3", "result drawn from inputs", o[k], 0);
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    int o[4];
    if (!rst_n) begin
      chk(!v0 && !v1, "R6", "valid_o during reset", int'(v0) + int'(v1), 0);
    end else if (!done) begin
      if (v0) begin
        if (q0.size() == 0) chk(1'b0, "R5", "unsigned valid_o without input", 1, 0);
        else begin
          o[0] = kval(a0, 0); o[1] = kval(a1, 0); o[2] = kval(a2, 0); o[3] = kval(a3, 0);
          judge(q0.pop_front(), o, 1'b0, t0.pop_front(), LAT0, g0.pop_front());
        end
      end
      if (v1) begin
        if (q1.size() == 0) chk(1'b0, "R5", "signed valid_o without input", 1, 0);
        else begin
          o[0] = kval(b0, 1); o[1] = kval(b1, 1); o[2] = kval(b2, 1); o[3] = kval(b3, 1);
          judge(q1.pop_front(), o, 1'b1, t1.pop_front(), LAT1, "R4");
        end
      end
    end
  end

  task automatic send(input logic [8*KW-1:0] k, input string tag);
    @(posedge clk); #1;
    valid = 1'b1;
    keys  = k;
    q0.push_back(k); t0.push_back(cyc); g0.push_back(tag);
    q1.push_back(k); t1.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 1'b0;
      keys  = 24'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [8*KW-1:0] k;
    valid = 1'b1;
    keys  = 24'hFAC688;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    valid = 1'b0;
    idle(4);
    // zero-one sweep, back to back
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) k[i*KW +: KW] = p[i] ? 3'd3 : 3'd0;
      send(k, "R1");
    end
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) k[i*KW +: KW] = p[i] ? 3'd7 : 3'd4;
      send(k, "R1");
    end
    // all keys equal
    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < 8; i++) k[i*KW +: KW] = 3'(v);
      send(k, "R7");
    end
    // random stream with gaps
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3) == 0) idle(1);
      send(24'($urandom), "R1");
    end
    idle(10);
    chk(q0.size() == 0, "R8", "unsigned results outstanding", q0.size(), 0);
    chk(q1.size() == 0, "R8", "signed results outstanding", q1.size(), 0);
    finish_run();
  end
endmodule